// File: doc/BRIEF.md
# Block Bit Interleaver with Zero Padding

This block sits between a rate-1/2 convolutional encoder and a 16-point constellation mapper. On its forward path it takes the encoder's 2-bit output words one at a time and gathers them into a 52-bit block. It then reorders the bits with a fixed permutation. The permutation has two steps: the bits go into a 13-column by 4-row array row by row and come out column by column, and then neighbouring bits swap in pairs so that their significance within a 4-bit symbol alternates. The block is presented whole, with a valid/ready handshake. When the encoded stream ends partway through a block, a flush request fills the unused positions with zeros and sends the block out.

The receive path of the same block reverses this. It gathers 4-bit words from the demapper until it holds 52 bits, applies the inverse permutation, and emits the result as 2-bit words for a decoder. This path has valid/ready handshakes on both sides. The permutation is wiring fixed at elaboration by three parameters: the column count, the row count and the pair rotation. It cannot be changed at run time.

Top module: `blk_interleaver`

## Requirements
- R1: A 2-bit word is taken on a clock edge where `in_valid` and `in_ready` are both high. Bit b of the n-th word taken since the last block boundary (n counted from 0) becomes block bit 2n+b.
- R2: On the edge that takes the 26th word of a block, the block is formed. `blk_valid` is high from the next cycle and stays high until the edge where `blk_ready` is also high. Blocks come out in the order they were formed.
- R3: Block bit k appears at `blk_data[j]`, where i = 4*(k mod 13) + floor(k/13) and j = 2*floor(i/2) + ((i + 52 - floor(13*i/52)) mod 2).
- R4: `flush` takes effect on an edge where `in_ready` is high and at least one bit is pending, counting a word taken on that same edge. The partial block is then formed with all untaken positions at zero, and the next word starts a new block.
- R5: A `flush` with no pending bits and no word taken forms no block.
- R6: While `blk_valid` is high and `blk_ready` is low, `in_ready` is low, no word is taken, and `blk_data` holds its value.
- R7: A 4-bit word is taken on an edge where `sym_valid` and `sym_ready` are both high. Bit b of the m-th word of a block becomes received bit 4m+b. After 13 words, `sym_ready` stays low until the collected block has moved into the output stage.
- R8: The received block is reordered so that output bit k equals received bit j(k), with j as in R3. It is emitted as 26 words on `dec_bits`: word n carries output bits 2n (in bit 0) and 2n+1 (in bit 1), lowest n first. Each word advances on an edge where `dec_valid` and `dec_ready` are both high.
- R9: Passing a block through the forward path and then feeding the resulting `blk_data` to the receive path, 4 bits at a time from bit 0 upward, returns the original 52 block bits in their original order.
- R10: While `dec_valid` is high and `dec_ready` is low, `dec_valid` stays high and `dec_bits` holds its value.
- R11: After reset, `in_ready` and `sym_ready` are high and `blk_valid` and `dec_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Encoder word valid |
| in_ready | output | 1 | Forward path can take a word |
| in_bits | input | 2 | Encoder output pair |
| flush | input | 1 | Close the partial block with zero padding |
| blk_valid | output | 1 | Permuted block is available |
| blk_ready | input | 1 | Mapper takes the block |
| blk_data | output | 52 | Permuted block |
| sym_valid | input | 1 | Demapper word valid |
| sym_ready | output | 1 | Receive path can take a word |
| sym_bits | input | 4 | Demapped 4-bit word |
| dec_valid | output | 1 | Decoder word valid |
| dec_ready | input | 1 | Decoder takes the word |
| dec_bits | output | 2 | De-permuted bit pair |

## Verification
The bench builds the block with its default parameters: 13 columns, 4 rows, a pair rotation of 2, 2-bit input words and 4-bit symbol words. With these values a full block takes 26 forward words and 13 receive words, and the pair swap in the second permutation step is active. Random flush requests therefore produce padded blocks at many different fill levels. Random stalls on both ready inputs drive the forward path into back-pressure and keep the receive path's collector full while the output stage is still emitting. Every block the forward path produces is fed back through the receive path, which closes the round trip.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  // Destination position of source bit k after the two-step permutation.
  function automatic int ilv_map(input int k, input int ncol, input int nrow, input int rot);
    int blk;
    int i;
    blk = ncol * nrow;
    i   = nrow * (k % ncol) + k / ncol;
    return rot * (i / rot) + ((i + blk - (ncol * i) / blk) % rot);
  endfunction

endpackage

// File: rtl/ilv_perm_net.sv
module ilv_perm_net #(
  parameter int NCOL    = 13,
  parameter int NROW    = 4,
  parameter int ROT     = 2,
  parameter bit INVERSE = 1'b0,
  localparam int BLK    = NCOL * NROW
) (
  input  logic [BLK-1:0] din,
  output logic [BLK-1:0] dout
);

  for (genvar k = 0; k < BLK; k++) begin : g_bit
    localparam int J = ilv_pkg::ilv_map(k, NCOL, NROW, ROT);
    if (!INVERSE) begin : g_fwd
      assign dout[J] = din[k];
    end else begin : g_inv
      assign dout[k] = din[J];
    end
  end

endmodule

// File: rtl/ilv_pack_path.sv
module ilv_pack_path #(
  parameter int IW   = 2,
  parameter int NCOL = 13,
  parameter int NROW = 4,
  parameter int ROT  = 2,
  localparam int BLK = NCOL * NROW,
  localparam int WPB = BLK / IW,
  localparam int CW  = $clog2(WPB)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [IW-1:0]  in_bits,
  input  logic           flush,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [BLK-1:0] out_data
);

  logic [BLK-1:0] acc_q;
  logic [BLK-1:0] nxt;
  logic [BLK-1:0] perm;
  logic [BLK-1:0] od_q;
  logic [CW-1:0]  cnt_q;
  logic           ov_q;
  logic           take;
  logic           last;
  logic           fl;
  logic           emit;

  assign in_ready  = !ov_q || out_ready;
  assign take      = in_valid && in_ready;
  assign last      = take && (cnt_q == CW'(WPB - 1));
  assign fl        = flush && in_ready && (take || cnt_q != '0);
  assign emit      = last || fl;
  assign out_valid = ov_q;
  assign out_data  = od_q;

  always_comb begin
    nxt = acc_q;
    if (take) nxt[int'(cnt_q) * IW +: IW] = in_bits;
  end

  ilv_perm_net #(
    .NCOL(NCOL), .NROW(NROW), .ROT(ROT), .INVERSE(1'b0)
  ) u_fwd (
    .din (nxt),
    .dout(perm)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      cnt_q <= '0;
      ov_q  <= 1'b0;
      od_q  <= '0;
    end else if (emit) begin
      acc_q <= '0;
      cnt_q <= '0;
      od_q  <= perm;
      ov_q  <= 1'b1;
    end else begin
      if (take) begin
        acc_q <= nxt;
        cnt_q <= cnt_q + 1'b1;
      end
      if (out_ready) ov_q <= 1'b0;
    end
  end

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    int'(cnt_q) < WPB); // R1
  AST_FULL_EMIT: assert property (@(posedge clk) disable iff (rst)
    last |=> (ov_q && cnt_q == '0)); // R2
  AST_PERM_WEIGHT: assert property (@(posedge clk) disable iff (rst)
    emit |=> ($countones(od_q) == $past($countones(nxt)))); // R3
  AST_HOLD_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (ov_q && !out_ready) |=> (ov_q && $stable(od_q))); // R6
  AST_STALL_ACC: assert property (@(posedge clk) disable iff (rst)
    (ov_q && !out_ready) |=> ($stable(cnt_q) && $stable(acc_q))); // R6

endmodule

// File: rtl/ilv_unpack_path.sv
module ilv_unpack_path #(
  parameter int SW    = 4,
  parameter int OW    = 2,
  parameter int NCOL  = 13,
  parameter int NROW  = 4,
  parameter int ROT   = 2,
  localparam int BLK  = NCOL * NROW,
  localparam int WIN  = BLK / SW,
  localparam int WOUT = BLK / OW,
  localparam int CIW  = $clog2(WIN),
  localparam int COW  = $clog2(WOUT)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [SW-1:0] in_bits,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [OW-1:0] out_bits
);

  logic [BLK-1:0] cacc_q;
  logic [BLK-1:0] deperm;
  logic [BLK-1:0] ebuf_q;
  logic [CIW-1:0] ccnt_q;
  logic [COW-1:0] ecnt_q;
  logic           cfull_q;
  logic           ev_q;
  logic           take;
  logic           load;
  logic           pop;

  assign in_ready  = !cfull_q;
  assign take      = in_valid && !cfull_q;
  assign load      = cfull_q && !ev_q;
  assign pop       = ev_q && out_ready;
  assign out_valid = ev_q;
  assign out_bits  = ebuf_q[OW-1:0];

  ilv_perm_net #(
    .NCOL(NCOL), .NROW(NROW), .ROT(ROT), .INVERSE(1'b1)
  ) u_inv (
    .din (cacc_q),
    .dout(deperm)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cacc_q  <= '0;
      ccnt_q  <= '0;
      cfull_q <= 1'b0;
      ebuf_q  <= '0;
      ecnt_q  <= '0;
      ev_q    <= 1'b0;
    end else begin
      if (take) begin
        cacc_q[int'(ccnt_q) * SW +: SW] <= in_bits;
        if (ccnt_q == CIW'(WIN - 1)) begin
          ccnt_q  <= '0;
          cfull_q <= 1'b1;
        end else begin
          ccnt_q <= ccnt_q + 1'b1;
        end
      end
      if (load) begin
        cfull_q <= 1'b0;
        ebuf_q  <= deperm;
        ecnt_q  <= '0;
        ev_q    <= 1'b1;
      end else if (pop) begin
        ebuf_q <= ebuf_q >> OW;
        if (ecnt_q == COW'(WOUT - 1)) begin
          ecnt_q <= '0;
          ev_q   <= 1'b0;
        end else begin
          ecnt_q <= ecnt_q + 1'b1;
        end
      end
    end
  end

  AST_COLLECT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (cfull_q && ev_q) |=> ($stable(cacc_q) && cfull_q)); // R7
  AST_EMIT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    int'(ecnt_q) < WOUT); // R8
  AST_DEC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ev_q && !out_ready) |=> (ev_q && $stable(out_bits))); // R10

endmodule

// File: rtl/blk_interleaver.sv
module blk_interleaver #(
  parameter int IN_W  = 2,
  parameter int SYM_W = 4,
  parameter int NCOL  = 13,
  parameter int NROW  = 4,
  parameter int ROT   = 2,
  localparam int BLK  = NCOL * NROW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_bits,
  input  logic             flush,
  output logic             blk_valid,
  input  logic             blk_ready,
  output logic [BLK-1:0]   blk_data,
  input  logic             sym_valid,
  output logic             sym_ready,
  input  logic [SYM_W-1:0] sym_bits,
  output logic             dec_valid,
  input  logic             dec_ready,
  output logic [IN_W-1:0]  dec_bits
);

  ilv_pack_path #(
    .IW(IN_W), .NCOL(NCOL), .NROW(NROW), .ROT(ROT)
  ) u_pack (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_bits  (in_bits),
    .flush    (flush),
    .out_valid(blk_valid),
    .out_ready(blk_ready),
    .out_data (blk_data)
  );

  ilv_unpack_path #(
    .SW(SYM_W), .OW(IN_W), .NCOL(NCOL), .NROW(NROW), .ROT(ROT)
  ) u_unpack (
    .clk      (clk),
    .rst      (rst),
    .in_valid (sym_valid),
    .in_ready (sym_ready),
    .in_bits  (sym_bits),
    .out_valid(dec_valid),
    .out_ready(dec_ready),
    .out_bits (dec_bits)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!blk_valid && !dec_valid && in_ready && sym_ready)); // R11

endmodule

// File: tb/blk_interleaver_tb_top.sv
module blk_interleaver_tb_top;

  localparam int NC = 13;
  localparam int NR = 4;
  localparam int RT = 2;
  localparam int NB = NC * NR;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [1:0]    in_bits = '0;
  logic          flush = 1'b0;
  logic          blk_valid;
  logic          blk_ready = 1'b0;
  logic [NB-1:0] blk_data;
  logic          sym_valid = 1'b0;
  logic          sym_ready;
  logic [3:0]    sym_bits = '0;
  logic          dec_valid;
  logic          dec_ready = 1'b0;
  logic [1:0]    dec_bits;

  always #5 clk = ~clk;

  blk_interleaver dut_i (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_bits(in_bits), .flush(flush),
    .blk_valid(blk_valid), .blk_ready(blk_ready), .blk_data(blk_data),
    .sym_valid(sym_valid), .sym_ready(sym_ready), .sym_bits(sym_bits),
    .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_bits(dec_bits)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Destination index from the R3 formula.
  function automatic int dst(input int k);
    int i;
    i = NR * (k % NC) + k / NC;
    return RT * (i / RT) + ((i + NB - (NC * i) / NB) % RT);
  endfunction

  function automatic logic [NB-1:0] fwd(input logic [NB-1:0] b);
    logic [NB-1:0] r;
    r = '0;
    for (int k = 0; k < NB; k++) r[dst(k)] = b[k];
    return r;
  endfunction

  function automatic logic [NB-1:0] inv(input logic [NB-1:0] b);
    logic [NB-1:0] r;
    for (int k = 0; k < NB; k++) r[k] = b[dst(k)];
    return r;
  endfunction

  // forward-path model state
  logic [NB-1:0] m_blk = '0;
  int            m_cnt = 0;
  logic [NB-1:0] exp_q[$];
  logic [NB-1:0] raw_q[$];
  logic [NB-1:0] got_q[$];
  string         tag_q[$];
  bit            hold_p = 0;
  logic [NB-1:0] hold_d;

  task automatic close_blk(input string tag);
    exp_q.push_back(fwd(m_blk));
    raw_q.push_back(m_blk);
    tag_q.push_back(tag);
    m_blk = '0;
    m_cnt = 0;
  endtask

  task automatic cyc(input logic v, input logic [1:0] b, input logic f, input logic r);
    logic [NB-1:0] e;
    string t;
    @(posedge clk); #2;
    in_valid = v; in_bits = b; flush = f; blk_ready = r;
    @(negedge clk);
    if (hold_p) chk(blk_valid && blk_data == hold_d, "R6 block held", blk_data, hold_d);
    hold_p = 0;
    if (blk_valid && !blk_ready) begin
      chk(!in_ready, "R6 input stalled", in_ready, 0);
      hold_p = 1;
      hold_d = blk_data;
    end
    if (blk_valid && blk_ready) begin
      if (exp_q.size() == 0) chk(0, "R2 unexpected block", blk_data, 0);
      else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(blk_data == e, t, blk_data, e);
        got_q.push_back(blk_data);
      end
    end
    if (in_valid && in_ready) begin
      m_blk[2 * m_cnt +: 2] = in_bits;
      m_cnt++;
      if (m_cnt == NB / 2) close_blk("R1 R2 R3 full block");
    end
    if (flush && in_ready && m_cnt != 0) close_blk("R4 padded block");
  endtask

  // receive-path model state
  logic [3:0] sw_q[$];
  logic [1:0] dw_q[$];
  string      dt_q[$];
  bit         dhold = 0;
  logic [1:0] dhold_d;

  task automatic load_rx(input logic [NB-1:0] src, input logic [NB-1:0] expect_blk, input string tag);
    for (int m = 0; m < NB / 4; m++) sw_q.push_back(src[4 * m +: 4]);
    for (int n = 0; n < NB / 2; n++) begin
      dw_q.push_back(expect_blk[2 * n +: 2]);
      dt_q.push_back(tag);
    end
  endtask

  task automatic dcyc(input logic v, input logic r);
    logic [1:0] e;
    string t;
    @(posedge clk); #2;
    sym_valid = v && (sw_q.size() > 0);
    sym_bits  = (sw_q.size() > 0) ? sw_q[0] : 4'h0;
    dec_ready = r;
    @(negedge clk);
    if (dhold) chk(dec_valid && dec_bits == dhold_d, "R10 output held", dec_bits, dhold_d);
    dhold   = dec_valid && !dec_ready;
    dhold_d = dec_bits;
    if (dec_valid && dec_ready) begin
      if (dw_q.size() == 0) chk(0, "R8 unexpected word", dec_bits, 0);
      else begin
        e = dw_q.pop_front();
        t = dt_q.pop_front();
        chk(dec_bits == e, t, dec_bits, e);
      end
    end
    if (sym_valid && sym_ready) void'(sw_q.pop_front());
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    logic [NB-1:0] rb;
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1, "R11 in_ready after reset", in_ready, 1);
    chk(blk_valid == 1'b0, "R11 blk_valid after reset", blk_valid, 0);
    chk(sym_ready == 1'b1, "R11 sym_ready after reset", sym_ready, 1);
    chk(dec_valid == 1'b0, "R11 dec_valid after reset", dec_valid, 0);

    // directed: one full block with a counting pattern
    for (int n = 0; n < NB / 2; n++) cyc(1'b1, 2'(n), 1'b0, 1'b1);
    cyc(1'b0, 2'b00, 1'b0, 1'b1);
    cyc(1'b0, 2'b00, 1'b0, 1'b1);
    // R5: flush with nothing pending
    cyc(1'b0, 2'b00, 1'b1, 1'b1);
    cyc(1'b0, 2'b00, 1'b0, 1'b1);
    chk(blk_valid == 1'b0, "R5 idle flush forms no block", blk_valid, 0);
    // R4: single word plus flush on the same edge
    cyc(1'b1, 2'b11, 1'b1, 1'b1);
    cyc(1'b0, 2'b00, 1'b0, 1'b1);
    cyc(1'b0, 2'b00, 1'b0, 1'b1);
    // R4: flush on the closing word of a full block
    for (int n = 0; n < NB / 2; n++) cyc(1'b1, 2'b10, n == NB / 2 - 1, 1'b1);
    // R6: back-pressure with input offered
    for (int n = 0; n < NB / 2; n++) cyc(1'b1, 2'b01, 1'b0, 1'b0);
    for (int n = 0; n < 6; n++) cyc(1'b1, 2'b11, 1'b0, 1'b0);
    for (int n = 0; n < 4; n++) cyc(1'b0, 2'b00, 1'b0, 1'b1);

    // random traffic
    for (int n = 0; n < 2500; n++)
      cyc(($urandom % 4) != 0, 2'($urandom), ($urandom % 40) == 0, ($urandom % 4) != 0);
    cyc(1'b0, 2'b00, 1'b1, 1'b1);
    for (int n = 0; n < 6; n++) cyc(1'b0, 2'b00, 1'b0, 1'b1);
    chk(exp_q.size() == 0, "R2 every formed block delivered", exp_q.size(), 0);

    // receive path: directed blocks against the inverse map, then round trip
    load_rx({{(NB-1){1'b0}}, 1'b1}, inv({{(NB-1){1'b0}}, 1'b1}), "R8 single-bit block");
    for (int n = 0; n < 3; n++) begin
      rb = {$urandom, $urandom};
      load_rx(rb, inv(rb), "R8 random block");
    end
    for (int n = 0; n < got_q.size(); n++) load_rx(got_q[n], raw_q[n], "R9 round trip");

    for (int n = 0; n < 60; n++) dcyc(1'b1, 1'b0);
    chk(sym_ready == 1'b0, "R7 collector full stalls input", sym_ready, 0);
    chk(dec_valid == 1'b1, "R10 output waiting", dec_valid, 1);
    for (int n = 0; n < 60000 && (dw_q.size() != 0 || sw_q.size() != 0); n++)
      dcyc(($urandom % 3) != 0, ($urandom % 3) != 0);
    for (int n = 0; n < 4; n++) dcyc(1'b0, 1'b1);
    chk(dw_q.size() == 0, "R8 every word emitted", dw_q.size(), 0);
    chk(dec_valid == 1'b0, "R8 output idle at end", dec_valid, 0);

    finish_run();
  end

endmodule